// File: doc/BRIEF.md
# SPI Flash Sector Write Sequencer

This block drives a serial NOR flash over a four-wire SPI link (mode 0, most significant bit first) to rewrite one sector. A start pulse hands it a sector number, the sector size as a power-of-two exponent, and the erase opcode for that sector size. The block then polls the flash status until it is idle, sends write enable, and erases the sector. After that it takes a byte stream on a valid/ready input and writes it into the sector one 256-byte page at a time.

A page program command is opened only when a byte is waiting, and it is closed when the byte address reaches the end of a page. The next byte then opens a fresh program cycle, with its own status wait and write enable. A finish pulse releases the flash. A next pulse releases the flash and erases the following sector. A start that would cut into an open program command is refused. So is a flash that stays busy for too long. In both cases the block holds an error code until the next start.

Back-pressure: `in_ready` is high only while a page program is open and the link is idle. A byte moves on a cycle where `in_valid` and `in_ready` are both high. The sender holds `in_valid` and `in_data` until that cycle. A waiting byte with no open program is what starts the page-open sequence. During that sequence `in_ready` stays low.

Top module: `flash_sector_writer`

## Requirements
- R1: A start that arrives while a page program is open (chip select low) sets the error code to 4. The block then deselects the flash and issues no erase.
- R2: Each busy wait selects the flash and sends opcode 0x05, then reads status bytes while chip select stays low. The block goes on only after a status byte with bit 0 clear. After POLL_LIMIT reads with bit 0 set, it sets the error code to 2 and deselects. No write enable, erase or program opcode reaches the flash while it reports busy.
- R3: Sector setup runs in this order: busy wait, opcode 0x06 alone, then the erase opcode with three address bytes. The address is sent high byte first. The upper 16 bits are the sector number shifted left by (exponent - 8), and the low byte is 0.
- R4: After the erase, chip select stays high, `in_ready` stays low and no program command is sent until a data byte is offered.
- R5: Opening a page program runs in this order: deselect, busy wait, opcode 0x06 alone, then opcode 0x02 with the upper address bytes and a low byte of 0.
- R6: SPI mode 0. SCK idles low, MOSI changes only while SCK is low, and chip select changes only while SCK is low. Data bytes reach the flash unchanged, most significant bit first, at consecutive addresses.
- R7: After the byte at low address 0xFF, the program command is closed. The next byte opens a new program at the next page.
- R8: A next pulse while streaming deselects the flash and runs sector setup for the stored sector number plus 1.
- R9: A finish pulse while streaming deselects the flash and returns to idle. Every deselect gives exactly 8 SCK pulses with chip select high.
- R10: A nonzero error code holds, with `in_ready` low and chip select high, until the next start. That start clears it.
- R11: `in_ready` is low whenever `busy` is high. Every accepted byte is written exactly once.
- R12: After reset, chip select is high, SCK is low, and `busy`, `in_ready` and the error code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse: begin rewriting `sector` |
| sector | input | SECT_W | Sector number |
| sect_exp | input | EXP_W | Sector size as log2 of bytes (8 or more) |
| erase_op | input | 8 | Erase opcode for this sector size |
| next_req | input | 1 | Pulse: close and move on to the next sector |
| finish_req | input | 1 | Pulse: close and go idle |
| in_valid | input | 1 | Data byte offered |
| in_data | input | 8 | Data byte |
| in_ready | output | 1 | Data byte taken this cycle if valid |
| busy | output | 1 | A command sequence is running |
| err_code | output | 3 | 0 none, 2 timeout, 4 pending operation |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Three byte streams are used.

- A 300-byte ramp with periodic gaps in `in_valid`. It crosses one page boundary and stops mid-page. This separates a correct close and reopen at the boundary, with a new address, from a command that runs past the page end. Comparing the flash image also exposes bit-order errors and dropped or doubled bytes.
- A single byte followed by a start. This shows that a start is refused while a program command is open.
- A ten-byte burst followed by a next pulse. This checks that the next-sector erase goes to the following address.

Two further cases target the setup path alone. Sectors with different exponents and erase opcodes check address scaling. A flash that never becomes ready must end in a timeout with nothing erased.

// File: rtl/flsw_pkg.sv
package flsw_pkg;
  localparam int ADDR_HI_W = 16;
  localparam int ERR_W     = 3;

  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;

  localparam logic [ERR_W-1:0] ERC_NONE    = 3'd0;
  localparam logic [ERR_W-1:0] ERC_TIMEOUT = 3'd2;
  localparam logic [ERR_W-1:0] ERC_PENDING = 3'd4;

  typedef enum logic [4:0] {
    S_IDLE, S_ERR, S_STREAM, S_DATA,
    S_POLL_CMD, S_POLL_RD, S_POLL_DES,
    S_WE_CMD, S_WE_DES,
    S_CMD, S_A2, S_A1, S_A0,
    S_ER_DES, S_PG_DES, S_PRE_DES, S_NXT_DES, S_FIN_DES, S_ERR_DES
  } fsm_t;
endpackage

// File: rtl/spi_byte_xfer.sv
module spi_byte_xfer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] tx,
  output logic         busy,
  output logic         done,
  output logic         last_bit,
  output logic         sck,
  output logic         mosi,
  input  logic         miso
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sh;
  logic [CW-1:0] bc;
  logic          act, ph, sck_q, done_q, rx_q;

  // Two system cycles per bit: low half drives MOSI, rising edge samples MISO.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      bc     <= '0;
      act    <= 1'b0;
      ph     <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      rx_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go && !act) begin
        sh  <= tx;
        act <= 1'b1;
        ph  <= 1'b0;
        bc  <= '0;
      end else if (act) begin
        if (!ph) begin
          sck_q <= 1'b1;
          ph    <= 1'b1;
          rx_q  <= miso;
        end else begin
          sck_q <= 1'b0;
          ph    <= 1'b0;
          sh    <= {sh[W-2:0], 1'b0};
          bc    <= bc + 1'b1;
          if (bc == CW'(W-1)) begin
            act    <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign busy     = act;
  assign done     = done_q;
  assign last_bit = rx_q;
  assign sck      = sck_q;
  assign mosi     = sh[W-1];
endmodule

// File: rtl/page_addr_track.sv
module page_addr_track #(
  parameter int SECT_W = 16,
  parameter int EXP_W  = 5,
  parameter int HI_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SECT_W-1:0] sect_in,
  input  logic [EXP_W-1:0]  exp_in,
  input  logic              bump_sect,
  input  logic              tick,
  output logic [HI_W-1:0]   hi,
  output logic              last_in_page
);
  logic [SECT_W-1:0] sect_q;
  logic [EXP_W-1:0]  exp_q;
  logic [HI_W-1:0]   hi_q;
  logic [7:0]        lo_q;

  function automatic logic [HI_W-1:0] page_of(input logic [SECT_W-1:0] s,
                                              input logic [EXP_W-1:0] e);
    return HI_W'(s) << (e - EXP_W'(8));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sect_q <= '0;
      exp_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (load) begin
      sect_q <= sect_in;
      exp_q  <= exp_in;
      hi_q   <= page_of(sect_in, exp_in);
      lo_q   <= '0;
    end else if (bump_sect) begin
      sect_q <= sect_q + 1'b1;
      hi_q   <= page_of(sect_q + 1'b1, exp_q);
      lo_q   <= '0;
    end else if (tick) begin
      lo_q <= lo_q + 1'b1;
      if (lo_q == 8'hFF) hi_q <= hi_q + 1'b1;
    end
  end

  assign hi           = hi_q;
  assign last_in_page = (lo_q == 8'hFF);
endmodule

// File: rtl/flash_sector_writer.sv
module flash_sector_writer
  import flsw_pkg::*;
#(
  parameter int SECT_W     = 16,
  parameter int EXP_W      = 5,
  parameter int POLL_LIMIT = 65535
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SECT_W-1:0] sector,
  input  logic [EXP_W-1:0]  sect_exp,
  input  logic [7:0]        erase_op,
  input  logic              next_req,
  input  logic              finish_req,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              busy,
  output logic [ERR_W-1:0]  err_code,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int PW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;

  fsm_t                 state;
  logic [7:0]           er_op_q, dat_q, tx;
  logic                 issued, need_pp, pp_open, is_erase, cs_n_q;
  logic [PW-1:0]        poll_cnt;
  logic [ERR_W-1:0]     err_q;
  logic                 byte_st, sel, go, x_busy, x_done, x_bit;
  logic                 trk_load, trk_bump, trk_tick, last_in_page;
  logic [ADDR_HI_W-1:0] hi;

  always_comb begin
    byte_st = !(state inside {S_IDLE, S_ERR, S_STREAM});
    sel     = (state inside {S_POLL_CMD, S_POLL_RD, S_WE_CMD, S_CMD, S_A2,
                             S_A1, S_A0, S_DATA}) || (state == S_STREAM && pp_open);
    case (state)
      S_POLL_CMD: tx = OP_RDSR;
      S_WE_CMD:   tx = OP_WREN;
      S_CMD:      tx = is_erase ? er_op_q : OP_PROG;
      S_A2:       tx = hi[15:8];
      S_A1:       tx = hi[7:0];
      S_DATA:     tx = dat_q;
      default:    tx = 8'h00;
    endcase
  end

  assign go       = byte_st && !issued && !x_busy;
  assign in_ready = (state == S_STREAM) && pp_open && !start && !next_req && !finish_req;
  assign busy     = byte_st;
  assign trk_load = start && ((state inside {S_IDLE, S_ERR}) ||
                              (state == S_STREAM && !pp_open));
  assign trk_bump = (state == S_STREAM) && !start && next_req;
  assign trk_tick = (state == S_DATA) && x_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      er_op_q  <= '0;
      dat_q    <= '0;
      issued   <= 1'b0;
      need_pp  <= 1'b0;
      pp_open  <= 1'b0;
      is_erase <= 1'b0;
      cs_n_q   <= 1'b1;
      poll_cnt <= '0;
      err_q    <= ERC_NONE;
    end else begin
      cs_n_q <= !sel;
      if (go) issued <= 1'b1;
      else if (x_done) issued <= 1'b0;

      if (trk_load) begin
        err_q    <= ERC_NONE;
        er_op_q  <= erase_op;
        is_erase <= 1'b1;
        need_pp  <= 1'b0;
        state    <= S_POLL_CMD;
      end else if (state == S_STREAM) begin
        if (start) begin
          err_q   <= ERC_PENDING;
          pp_open <= 1'b0;
          state   <= S_ERR_DES;
        end else if (next_req) begin
          is_erase <= 1'b1;
          pp_open  <= 1'b0;
          need_pp  <= 1'b0;
          state    <= S_NXT_DES;
        end else if (finish_req) begin
          pp_open <= 1'b0;
          need_pp <= 1'b0;
          state   <= S_FIN_DES;
        end else if (in_valid && need_pp) begin
          is_erase <= 1'b0;
          state    <= S_PRE_DES;
        end else if (in_valid && pp_open) begin
          dat_q <= in_data;
          state <= S_DATA;
        end
      end else if (x_done) begin
        case (state)
          S_POLL_CMD: begin
            poll_cnt <= '0;
            state    <= S_POLL_RD;
          end
          S_POLL_RD: begin
            if (!x_bit) state <= S_POLL_DES;
            else if (poll_cnt == PW'(POLL_LIMIT - 1)) begin
              err_q <= ERC_TIMEOUT;
              state <= S_ERR_DES;
            end else poll_cnt <= poll_cnt + 1'b1;
          end
          S_POLL_DES: state <= S_WE_CMD;
          S_WE_CMD:   state <= S_WE_DES;
          S_WE_DES:   state <= S_CMD;
          S_CMD:      state <= S_A2;
          S_A2:       state <= S_A1;
          S_A1:       state <= S_A0;
          S_A0: begin
            if (is_erase) state <= S_ER_DES;
            else begin
              pp_open <= 1'b1;
              need_pp <= 1'b0;
              state   <= S_STREAM;
            end
          end
          S_ER_DES, S_PG_DES: begin
            need_pp <= 1'b1;
            state   <= S_STREAM;
          end
          S_DATA: begin
            if (last_in_page) begin
              pp_open <= 1'b0;
              state   <= S_PG_DES;
            end else state <= S_STREAM;
          end
          S_PRE_DES, S_NXT_DES: state <= S_POLL_CMD;
          S_FIN_DES: state <= S_IDLE;
          S_ERR_DES: state <= S_ERR;
          default:   state <= S_IDLE;
        endcase
      end
    end
  end

  spi_byte_xfer #(.W(8)) i_xfer (
    .clk(clk), .rst_n(rst_n), .go(go), .tx(tx), .busy(x_busy), .done(x_done),
    .last_bit(x_bit), .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso)
  );

  page_addr_track #(.SECT_W(SECT_W), .EXP_W(EXP_W), .HI_W(ADDR_HI_W)) i_trk (
    .clk(clk), .rst_n(rst_n), .load(trk_load), .sect_in(sector), .exp_in(sect_exp),
    .bump_sect(trk_bump), .tick(trk_tick), .hi(hi), .last_in_page(last_in_page)
  );

  assign spi_cs_n = cs_n_q;
  assign err_code = err_q;
endmodule

// File: rtl/flsw_chk.sv
module flsw_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       in_ready,
  input logic [2:0] err_code,
  input logic       spi_cs_n,
  input logic       spi_sck,
  input logic       spi_mosi
);
  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 3'd0 && !start) |=> $stable(err_code));
  // R10
  err_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 3'd0) |-> !in_ready);
  // R2
  err_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code == 3'd0) || (err_code == 3'd2) || (err_code == 3'd4));
  // R4
  ready_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !spi_cs_n);
  // R11
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
  // R6
  cs_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_cs_n) |-> !spi_sck);
  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> $stable(spi_mosi));
endmodule

bind flash_sector_writer flsw_chk i_flsw_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .in_ready(in_ready),
  .err_code(err_code), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
);

// File: tb/test_flash_sector_writer.sv
module test_flash_sector_writer;
  localparam int PL = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start = 0, next_req = 0, finish_req = 0, in_valid = 0;
  logic [15:0] sector = 0;
  logic [4:0]  sect_exp = 5'd12;
  logic [7:0]  erase_op = 8'h20, in_data = 0;
  logic        in_ready, busy, spi_cs_n, spi_sck, spi_mosi, miso = 1'b0;
  logic [2:0]  err_code;

  flash_sector_writer #(.SECT_W(16), .EXP_W(5), .POLL_LIMIT(PL)) i_flash_sector_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .sector(sector), .sect_exp(sect_exp),
    .erase_op(erase_op), .next_req(next_req), .finish_req(finish_req),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .busy(busy),
    .err_code(err_code), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(miso)
  );

  int n_cmp = 0, n_bad = 0;
  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [7:0] m_op [64], m_a2 [64], m_a1 [64], m_a0 [64];
  int         m_nd [64];
  logic [7:0] mem [4096];
  int m_n = 0, bitc = 0, m_idx = 0, busy_left = 0, post_busy = 3, hi_clks = 0, early = 0, m_addr = 0;
  logic [7:0] sh_in = 0;
  logic open_t = 0;

  always @(negedge spi_cs_n) begin
    bitc = 0;
    open_t = 1;
  end

  always @(posedge spi_cs_n) if (open_t && m_n < 64) begin
    open_t = 0;
    if (m_op[m_n] == 8'h20 || m_op[m_n] == 8'hD8 || (m_op[m_n] == 8'h02 && m_nd[m_n] > 0))
      busy_left = post_busy;
    m_n++;
    hi_clks = 0;
  end

  always @(posedge spi_sck) begin
    if (!spi_cs_n && m_n < 64) begin
      sh_in = {sh_in[6:0], spi_mosi};
      bitc++;
      if (bitc % 8 == 0) begin
        m_idx = bitc / 8 - 1;
        if (m_idx == 0) begin
          m_op[m_n] = sh_in;
          m_nd[m_n] = 0;
          if (sh_in != 8'h05 && busy_left > 0) early++;
        end else if (m_op[m_n] == 8'h05) begin
          if (busy_left > 0) busy_left--;
        end else if (m_idx == 1) m_a2[m_n] = sh_in;
        else if (m_idx == 2) m_a1[m_n] = sh_in;
        else if (m_idx == 3) m_a0[m_n] = sh_in;
        else if (m_op[m_n] == 8'h02) begin
          m_addr = {m_a1[m_n][3:0], m_a0[m_n]} + m_idx - 4;
          mem[m_addr & 4095] = sh_in;
          m_nd[m_n]++;
        end
      end
    end else if (spi_cs_n) hi_clks++;
  end

  always @(negedge spi_sck) begin
    if (!spi_cs_n && bitc >= 8 && m_n < 64 && m_op[m_n] == 8'h05)
      miso = ((bitc % 8) == 7) ? (busy_left != 0) : 1'b0;
    else miso = 1'b0;
  end

  // ---------------- helpers ----------------
  task automatic wait_idle();
    int t = 0;
    @(negedge clk);
    while (busy && t < 20000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 20000) chk("watchdog wait", 1, 0);
  endtask

  task automatic pulse_start(input logic [15:0] s, input logic [4:0] e, input logic [7:0] op);
    sector = s; sect_exp = e; erase_op = op; start = 1;
    @(negedge clk); start = 0;
    wait_idle();
  endtask

  task automatic pulse_finish();
    finish_req = 1; @(negedge clk); finish_req = 0;
    wait_idle();
  endtask

  task automatic push(input logic [7:0] b);
    int t = 0;
    in_valid = 1; in_data = b;
    while (!in_ready && t < 20000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 20000) chk("watchdog push", 1, 0);
    @(negedge clk);
    in_valid = 0;
  endtask

  // ---------------- scenarios ----------------
  int b0 = 0;

  task automatic t_reset();
    chk("R12 cs_n", spi_cs_n, 1);
    chk("R12 sck", spi_sck, 0);
    chk("R12 ready", in_ready, 0);
    chk("R12 busy", busy, 0);
    chk("R12 err", err_code, 0);
  endtask

  task automatic t_erase();
    int base = m_n;
    post_busy = 3;
    pulse_start(16'd3, 5'd12, 8'h20);
    chk("R3 count", m_n - base, 3);
    chk("R2 status op", m_op[base], 8'h05);
    chk("R3 wren", m_op[base + 1], 8'h06);
    chk("R3 erase op", m_op[base + 2], 8'h20);
    chk("R3 a2", m_a2[base + 2], 8'h00);
    chk("R3 a1", m_a1[base + 2], 8'h30);
    chk("R3 a0", m_a0[base + 2], 8'h00);
    repeat (40) @(negedge clk);
    chk("R4 cs high", spi_cs_n, 1);
    chk("R4 no program", m_n - base, 3);
    chk("R4 ready low", in_ready, 0);
    b0 = m_n;
  endtask

  task automatic t_stream();
    int bad = 0;
    for (int i = 0; i < 300; i++) begin
      push(8'((i * 7 + 1) & 255));
      if (i % 5 == 4) @(negedge clk);
    end
    wait_idle();
    chk("R7 open count", m_n - b0, 5);
    pulse_finish();
    chk("R9 close count", m_n - b0, 6);
    chk("R5 status", m_op[b0], 8'h05);
    chk("R5 wren", m_op[b0 + 1], 8'h06);
    chk("R5 prog op", m_op[b0 + 2], 8'h02);
    chk("R5 prog a1", m_a1[b0 + 2], 8'h30);
    chk("R7 first page len", m_nd[b0 + 2], 256);
    chk("R7 second op", m_op[b0 + 5], 8'h02);
    chk("R7 second a1", m_a1[b0 + 5], 8'h31);
    chk("R7 second len", m_nd[b0 + 5], 44);
    for (int i = 0; i < 300; i++)
      if (mem[(16'h3000 + i) & 4095] != 8'((i * 7 + 1) & 255)) bad++;
    chk("R6 data image", bad, 0);
    chk("R9 deselect clocks", hi_clks, 8);
    chk("R9 idle cs", spi_cs_n, 1);
  endtask

  task automatic t_pending();
    int n;
    pulse_start(16'd5, 5'd12, 8'h20);
    push(8'hA5);
    wait_idle();
    chk("R11 ready open", in_ready, 1);
    chk("R1 cs low before", spi_cs_n, 0);
    n = m_n;
    start = 1; @(negedge clk); start = 0;
    wait_idle();
    chk("R1 err pending", err_code, 4);
    chk("R1 cs high", spi_cs_n, 1);
    chk("R1 no erase", m_n - n, 1);
    repeat (40) @(negedge clk);
    chk("R10 err held", err_code, 4);
    chk("R10 ready low", in_ready, 0);
    chk("R10 quiet", m_n - n, 1);
  endtask

  task automatic t_next();
    int n;
    pulse_start(16'd7, 5'd12, 8'h20);
    chk("R10 err cleared", err_code, 0);
    for (int i = 0; i < 10; i++) push(8'(i + 8'h40));
    wait_idle();
    n = m_n;
    next_req = 1; @(negedge clk); next_req = 0;
    wait_idle();
    chk("R8 count", m_n - n, 4);
    chk("R8 closed prog len", m_nd[n], 10);
    chk("R8 status", m_op[n + 1], 8'h05);
    chk("R8 wren", m_op[n + 2], 8'h06);
    chk("R8 erase op", m_op[n + 3], 8'h20);
    chk("R8 a1", m_a1[n + 3], 8'h80);
    chk("R8 a2", m_a2[n + 3], 8'h00);
    pulse_finish();
    pulse_start(16'd2, 5'd16, 8'hD8);
    chk("R3 exp16 op", m_op[m_n - 1], 8'hD8);
    chk("R3 exp16 a2", m_a2[m_n - 1], 8'h02);
    chk("R3 exp16 a1", m_a1[m_n - 1], 8'h00);
    pulse_finish();
  endtask

  task automatic t_timeout();
    int n;
    busy_left = 1000;
    n = m_n;
    pulse_start(16'd1, 5'd12, 8'h20);
    chk("R2 timeout err", err_code, 2);
    chk("R2 only status", m_n - n, 1);
    chk("R2 status op", m_op[n], 8'h05);
    chk("R2 cs high", spi_cs_n, 1);
    busy_left = 0;
    pulse_start(16'd1, 5'd12, 8'h20);
    chk("R10 cleared", err_code, 0);
    chk("R3 erase after", m_op[m_n - 1], 8'h20);
    pulse_finish();
    chk("R2 early", early, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_erase();
        t_stream();
        t_pending();
        t_next();
        t_timeout();
      end
      begin
        repeat (200000) @(posedge clk);
        chk("watchdog global", 1, 0);
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule